// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM's contents alive and brings the memory out of power-up. After reset it waits a programmed settle time. It then runs a fixed burst of refresh cycles on its own. Only after that does it raise `ready_o`, which tells the access sequencer that normal traffic may begin.

Once ready, an interval timer produces one refresh demand per programmed period. Demands that cannot be served at once are held in a small saturating backlog, so a long page access can delay refresh without losing any. The block raises `rfsh_req_o` while a demand is pending. A refresh starts in a cycle where the access sequencer returns `rfsh_gnt_i` and also reports itself idle with RAS high on `seq_idle_i`.

While a refresh cycle runs, the block owns the control strobes and signals this on `own_o`. Each refresh cycle uses the CAS-first ordering, so the DRAM's internal row counter supplies the row. No address is driven and the data pins are left alone. All strobes are active low. Every timing value is a whole number of clock cycles set by a parameter: settle time, burst length, interval, CAS lead, RAS-low width, and RAS and CAS precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, `ready_o`, `rfsh_req_o` and `own_o` are 0, and `cas_n_o`, `ras_n_o` and `we_n_o` are 1.
- R2: The first CAS falling edge after reset is seen exactly WAIT_CYC+1 clock edges after the first rising clock edge at which `rst_ni` is high.
- R3: Exactly BURST_N refresh cycles run before `ready_o` rises. During that burst, successive CAS falling edges are LEAD_CYC+RAS_LO_CYC+max(RAS_PRE_CYC,CAS_PRE_CYC)+1 cycles apart. `ready_o` never falls once it has risen, and `rfsh_req_o` stays 0 while `ready_o` is 0.
- R4: In each refresh cycle, CAS goes low for exactly LEAD_CYC cycles while RAS is still high. CAS then stays low for every cycle in which RAS is low.
- R5: In each refresh cycle, RAS is low for exactly RAS_LO_CYC cycles. RAS and CAS then rise together, and both stay high for max(RAS_PRE_CYC,CAS_PRE_CYC) cycles before `own_o` drops.
- R6: `we_n_o` is 1 in every cycle in which `own_o` is 1.
- R7: After `ready_o` rises, the timer adds one demand every INTERVAL_CYC cycles. With grant and idle held high, successive refreshes start exactly INTERVAL_CYC cycles apart. Missed demands do not shift this phase.
- R8: `rfsh_req_o` stays 1 until a grant is accepted. A refresh starts only in a cycle where `rfsh_req_o`, `rfsh_gnt_i` and `seq_idle_i` are all 1. A grant given while `seq_idle_i` is 0 has no effect.
- R9: Demands not yet granted accumulate up to BACKLOG_MAX, and any beyond that are dropped. When grants resume, exactly the stored number of refreshes run back to back.
- R10: While `own_o` is 0, `cas_n_o`, `ras_n_o` and `we_n_o` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_idle_i | input | 1 | Access sequencer is idle with RAS high |
| rfsh_gnt_i | input | 1 | Grant from the access sequencer |
| rfsh_req_o | output | 1 | Refresh demand pending |
| ready_o | output | 1 | Power-up sequence finished; normal access allowed |
| own_o | output | 1 | Block owns the control strobes this cycle |
| cas_n_o | output | 1 | Column strobe, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |

## Verification
A fault in the cycle sequencer's state or counter shows up within the same refresh cycle. It appears as a wrong count of CAS-lead, RAS-low or precharge cycles, measured at the strobe pins. A power-up counter that is off shifts the first CAS fall or the number of refreshes seen before `ready_o` rises, so the fault is visible well before normal traffic starts. A backlog fault shows up only once grants are withheld and then restored: the block runs too many or too few refreshes back to back. A timer phase error shifts the next refresh away from its exact interval slot.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    RF_IDLE  = 2'd0,
    RF_LEAD  = 2'd1,
    RF_RASLO = 2'd2,
    RF_PRE   = 2'd3
  } rf_state_e;

  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_BURST = 2'd1,
    PH_RUN   = 2'd2
  } pwr_phase_e;
endpackage

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned LEAD_CYC    = 1,
  parameter int unsigned RAS_LO_CYC  = 5,
  parameter int unsigned RAS_PRE_CYC = 3,
  parameter int unsigned CAS_PRE_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic done_o,
  output logic own_o,
  output logic cas_n_o,
  output logic ras_n_o,
  output logic we_n_o
);
  localparam int unsigned PRE_CYC = (RAS_PRE_CYC > CAS_PRE_CYC) ? RAS_PRE_CYC : CAS_PRE_CYC;
  localparam int unsigned MAX_A   = (LEAD_CYC > RAS_LO_CYC) ? LEAD_CYC : RAS_LO_CYC;
  localparam int unsigned MAX_LEN = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  rf_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_m1;
  logic          last;

  always_comb begin
    unique case (state_q)
      RF_LEAD:  len_m1 = CW'(LEAD_CYC - 1);
      RF_RASLO: len_m1 = CW'(RAS_LO_CYC - 1);
      RF_PRE:   len_m1 = CW'(PRE_CYC - 1);
      default:  len_m1 = '0;
    endcase
  end

  assign last = (cnt_q == len_m1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      RF_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = RF_LEAD;
      end
      RF_LEAD: begin
        cnt_d = last ? '0 : cnt_q + 1'b1;
        if (last) state_d = RF_RASLO;
      end
      RF_RASLO: begin
        cnt_d = last ? '0 : cnt_q + 1'b1;
        if (last) state_d = RF_PRE;
      end
      RF_PRE: begin
        cnt_d = last ? '0 : cnt_q + 1'b1;
        if (last) state_d = RF_IDLE;
      end
      default: state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle_o  = (state_q == RF_IDLE);
  assign done_o  = (state_q == RF_PRE) && last;
  assign own_o   = (state_q != RF_IDLE);
  // CAS low through lead and RAS-low phases; both rise together into precharge
  assign cas_n_o = !((state_q == RF_LEAD) || (state_q == RF_RASLO));
  assign ras_n_o = (state_q != RF_RASLO);
  assign we_n_o  = 1'b1;
endmodule

// File: rtl/rfsh_init_seq.sv
module rfsh_init_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 20000,
  parameter int unsigned BURST_N  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsm_idle_i,
  input  logic done_i,
  output logic start_o,
  output logic ready_o
);
  localparam int unsigned WW = $clog2(WAIT_CYC + 1);
  localparam int unsigned DW = $clog2(BURST_N + 1);

  pwr_phase_e    phase_q;
  logic [WW-1:0] wcnt_q;
  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      wcnt_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (wcnt_q == WW'(WAIT_CYC - 1)) phase_q <= PH_BURST;
          else wcnt_q <= wcnt_q + 1'b1;
        end
        PH_BURST: begin
          if (done_i) begin
            if (dcnt_q == DW'(BURST_N - 1)) phase_q <= PH_RUN;
            else dcnt_q <= dcnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  // burst refreshes need no grant: no access can be live before ready
  assign start_o = (phase_q == PH_BURST) && fsm_idle_i;
  assign ready_o = (phase_q == PH_RUN);
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned BACKLOG_MAX  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic take_i,
  output logic pending_o
);
  localparam int unsigned TW = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned BW = $clog2(BACKLOG_MAX + 1);

  logic [TW-1:0] tcnt_q;
  logic          tick;

  assign tick = run_i && (tcnt_q == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tcnt_q <= '0;
    else if (!run_i)  tcnt_q <= '0;
    else if (tick)    tcnt_q <= '0;
    else              tcnt_q <= tcnt_q + 1'b1;
  end

  generate
    if (BACKLOG_MAX == 1) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     flag_q <= 1'b0;
        else if (tick)   flag_q <= 1'b1;
        else if (take_i) flag_q <= 1'b0;
      end
      assign pending_o = flag_q;
    end else begin : g_count
      logic [BW-1:0] blog_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          blog_q <= '0;
        end else begin
          unique case ({tick, take_i})
            2'b10: if (blog_q != BW'(BACKLOG_MAX)) blog_q <= blog_q + 1'b1;
            2'b01: if (blog_q != '0) blog_q <= blog_q - 1'b1;
            default: ;
          endcase
        end
      end
      assign pending_o = (blog_q != '0);
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned WAIT_CYC     = 20000,
  parameter int unsigned BURST_N      = 8,
  parameter int unsigned INTERVAL_CYC = 1560,
  parameter int unsigned BACKLOG_MAX  = 7,
  parameter int unsigned LEAD_CYC     = 1,
  parameter int unsigned RAS_LO_CYC   = 5,
  parameter int unsigned RAS_PRE_CYC  = 3,
  parameter int unsigned CAS_PRE_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seq_idle_i,
  input  logic rfsh_gnt_i,
  output logic rfsh_req_o,
  output logic ready_o,
  output logic own_o,
  output logic cas_n_o,
  output logic ras_n_o,
  output logic we_n_o
);
  logic fsm_idle, fsm_done, init_start, pending, accept, start;

  rfsh_init_seq #(
    .WAIT_CYC (WAIT_CYC),
    .BURST_N  (BURST_N)
  ) i_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsm_idle_i (fsm_idle),
    .done_i     (fsm_done),
    .start_o    (init_start),
    .ready_o    (ready_o)
  );

  rfsh_interval_timer #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .BACKLOG_MAX  (BACKLOG_MAX)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ready_o),
    .take_i    (accept),
    .pending_o (pending)
  );

  assign rfsh_req_o = ready_o && pending && fsm_idle;
  assign accept     = rfsh_req_o && rfsh_gnt_i && seq_idle_i;
  assign start      = init_start || accept;

  rfsh_cycle_fsm #(
    .LEAD_CYC    (LEAD_CYC),
    .RAS_LO_CYC  (RAS_LO_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC),
    .CAS_PRE_CYC (CAS_PRE_CYC)
  ) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .idle_o  (fsm_idle),
    .done_o  (fsm_done),
    .own_o   (own_o),
    .cas_n_o (cas_n_o),
    .ras_n_o (ras_n_o),
    .we_n_o  (we_n_o)
  );
endmodule

// File: rtl/rfsh_sched_checker.sv
module rfsh_sched_checker #(
  parameter int unsigned RAS_LO_CYC = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic seq_idle_i,
  input logic rfsh_gnt_i,
  input logic rfsh_req_o,
  input logic ready_o,
  input logic own_o,
  input logic cas_n_o,
  input logic ras_n_o,
  input logic we_n_o
);
  localparam int unsigned CW = $clog2(RAS_LO_CYC + 2);
  logic [CW-1:0] ras_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ras_lo_cnt <= '0;
    else if (ras_n_o) ras_lo_cnt <= '0;
    else              ras_lo_cnt <= ras_lo_cnt + 1'b1;
  end

  assert_no_req_early_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !rfsh_req_o);
  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_cas_leads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  assert_cas_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);
  assert_ras_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (ras_lo_cnt == CW'(RAS_LO_CYC)));
  assert_we_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_o |-> we_n_o);
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_req_o && !(rfsh_gnt_i && seq_idle_i)) |=> rfsh_req_o);
  assert_start_granted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && $past(ready_o)) |-> $past(rfsh_gnt_i && seq_idle_i && rfsh_req_o));
  assert_idle_pins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_o |-> (cas_n_o && ras_n_o && we_n_o));
endmodule

bind dram_refresh_sched rfsh_sched_checker #(
  .RAS_LO_CYC (RAS_LO_CYC)
) i_rfsh_sched_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .seq_idle_i (seq_idle_i),
  .rfsh_gnt_i (rfsh_gnt_i),
  .rfsh_req_o (rfsh_req_o),
  .ready_o    (ready_o),
  .own_o      (own_o),
  .cas_n_o    (cas_n_o),
  .ras_n_o    (ras_n_o),
  .we_n_o     (we_n_o)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT   = 40;
  localparam int BURST  = 8;
  localparam int IVL    = 50;
  localparam int BMAX   = 3;
  localparam int LEAD   = 2;
  localparam int RASLO  = 4;
  localparam int RASPRE = 3;
  localparam int CASPRE = 2;
  localparam int PRE    = (RASPRE > CASPRE) ? RASPRE : CASPRE;
  localparam int GAP    = LEAD + RASLO + PRE + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic seq_idle = 1'b1;
  logic gnt = 1'b0;
  logic req, ready, own, cas_n, ras_n, we_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched #(
    .WAIT_CYC(WAIT), .BURST_N(BURST), .INTERVAL_CYC(IVL), .BACKLOG_MAX(BMAX),
    .LEAD_CYC(LEAD), .RAS_LO_CYC(RASLO), .RAS_PRE_CYC(RASPRE), .CAS_PRE_CYC(CASPRE)
  ) i_dram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_ni), .seq_idle_i(seq_idle), .rfsh_gnt_i(gnt),
    .rfsh_req_o(req), .ready_o(ready), .own_o(own),
    .cas_n_o(cas_n), .ras_n_o(ras_n), .we_n_o(we_n)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // pin monitor
  bit prev_cas = 1'b1, prev_own = 1'b0, prev_ready = 1'b0;
  int lead_n = 0, raslo_n = 0, pre_n = 0;
  bit seen_ras = 1'b0, hold_bad = 1'b0, we_bad = 1'b0;
  int idle_bad = 0, ready_drop = 0, early_req = 0, init_gap_bad = 0;
  int fall_cnt = 0, first_fall = -1, last_fall = 0;

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (prev_cas && !cas_n) begin
        if (fall_cnt == 0) first_fall = cyc;
        else if (!ready && (cyc - last_fall != GAP)) init_gap_bad++;
        fall_cnt++;
        last_fall = cyc;
      end
      if (own) begin
        if (!cas_n && ras_n && !seen_ras) lead_n++;
        if (!ras_n) begin
          raslo_n++;
          seen_ras = 1'b1;
          if (cas_n) hold_bad = 1'b1;
        end
        if (ras_n && cas_n && seen_ras) pre_n++;
        if (!we_n) we_bad = 1'b1;
      end else begin
        if (!cas_n || !ras_n || !we_n) idle_bad++;
      end
      if (prev_own && !own) begin
        chk(lead_n == LEAD, "R4 cas lead cycles", lead_n, LEAD);
        chk(!hold_bad, "R4 cas low while ras low", hold_bad, 0);
        chk(raslo_n == RASLO, "R5 ras low cycles", raslo_n, RASLO);
        chk(pre_n == PRE, "R5 precharge cycles", pre_n, PRE);
        chk(!we_bad, "R6 we high while owned", we_bad, 0);
        lead_n = 0; raslo_n = 0; pre_n = 0;
        seen_ras = 1'b0; hold_bad = 1'b0; we_bad = 1'b0;
      end
      if (prev_ready && !ready) ready_drop++;
      if (!ready && req) early_req++;
      prev_cas = cas_n;
      prev_own = own;
      prev_ready = ready;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic to_cyc(input int t);
    while (cyc < t) step();
  endtask

  initial begin
    int r0, f, f1, g, n0;
    step();
    step();
    chk(!ready && !req && !own, "R1 reset status outputs", {ready, req, own}, 0);
    chk(cas_n && ras_n && we_n, "R1 reset strobes high", {cas_n, ras_n, we_n}, 7);
    r0 = cyc;
    rst_ni = 1'b1;

    while (!ready) step();
    chk(first_fall == r0 + WAIT + 1, "R2 first cas fall", first_fall, r0 + WAIT + 1);
    chk(fall_cnt == BURST, "R3 burst refreshes before ready", fall_cnt, BURST);
    chk(init_gap_bad == 0, "R3 burst spacing", init_gap_bad, 0);
    chk(early_req == 0, "R3 no request before ready", early_req, 0);

    // continuous grant: steady interval
    gnt = 1'b1;
    n0 = fall_cnt;
    while (fall_cnt < n0 + 1) step();
    f1 = last_fall;
    while (fall_cnt < n0 + 2) step();
    f = last_fall;
    chk(f - f1 == IVL, "R7 refresh interval", f - f1, IVL);

    // withhold grant for four intervals
    gnt = 1'b0;
    n0 = fall_cnt;
    to_cyc(f + 150);
    chk(req == 1'b1, "R8 request held without grant", req, 1);
    chk(fall_cnt == n0, "R8 no refresh without grant", fall_cnt - n0, 0);
    to_cyc(f + 204);
    chk(fall_cnt == n0, "R8 no refresh before grant", fall_cnt - n0, 0);
    gnt = 1'b1;
    to_cyc(f + 245);
    chk(fall_cnt - n0 == BMAX, "R9 saturated backlog drained", fall_cnt - n0, BMAX);
    while (fall_cnt < n0 + BMAX + 1) step();
    chk(last_fall == f + 5 * IVL, "R7 phase kept after backlog", last_fall, f + 5 * IVL);

    // grant present but sequencer busy
    g = last_fall;
    seq_idle = 1'b0;
    n0 = fall_cnt;
    to_cyc(g + 120);
    chk(req == 1'b1, "R8 request held while busy", req, 1);
    chk(fall_cnt == n0, "R8 grant ignored while busy", fall_cnt - n0, 0);
    seq_idle = 1'b1;
    to_cyc(g + 145);
    chk(fall_cnt - n0 == 2, "R9 two stored demands drained", fall_cnt - n0, 2);
    while (fall_cnt < n0 + 3) step();
    chk(last_fall == g + 3 * IVL, "R7 next slot after busy", last_fall, g + 3 * IVL);

    step();
    chk(idle_bad == 0, "R10 strobes high when not owned", idle_bad, 0);
    chk(ready_drop == 0, "R3 ready never falls", ready_drop, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule